// File: doc/BRIEF.md
# MMU Miss and Fault Dispatcher

This block sits beside a translation look-aside buffer and decides what happens to each lookup. A hit completes at once with the physical address the buffer supplied. A miss is handled according to two things: whether the access is an application access or a debug access, and whether page-table walking is enabled. The block either hands the virtual address to a table walker and acts on the walker's verdict, or it freezes the requester, records the cause in a status register and can raise an interrupt. A software host must then clear the status before the requester may continue.

A small four-entry register file holds the interrupt status (write 1 to clear), the interrupt enables, a control register and a general-purpose register. The control register switches walking on and lets debug walks refill the buffer. The general-purpose register holds an override that turns every fault into an immediate bus-error response plus a one-cycle fault pulse, so the requester is never frozen. Only one translation is in flight at a time. The stalled access is abandoned and the requester presents it again once the stall falls.

Top module: `mmu_miss_dispatch`

## Requirements
- R1: A lookup accepted (lkpValid with lkpReady) with lkpHit set produces, in the next cycle, rspValid with rspErr low and rspPaddr equal to lkpPaddr.
- R2: An application miss with walking enabled (control register, address 2, bit 1) raises walkReq with walkVaddr equal to the lookup address. walkReq is held until walkDone. A successful walk (walkOk) yields, in the next cycle, a response carrying walkPaddr, together with a one-cycle refillEn carrying the lookup address and walkPaddr. No status bit is set.
- R3: An application walk that fails sets status bit 1 (translation fault). When the override is off, the block then stalls.
- R4: An application miss with walking disabled sets status bit 0 (buffer miss). When the override is off, the block raises stall, drops lkpReady and gives no response.
- R5: A debug walk that succeeds always responds with walkPaddr. It pulses refillEn only when control bit 3 (debug refill) is 1.
- R6: A debug walk that fails responds with rspErr high. It sets no status bit and does not stall.
- R7: A debug miss with walking disabled sets status bit 2 (debug miss). When the override is off, the block stalls.
- R8: irq is high exactly when some status bit and the enable bit at the same position (enable register, address 1) are both 1.
- R9: Writing the status register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. Once no status bit remains, stall falls one cycle after the clearing write and lkpReady returns.
- R10: With the override on (general-purpose register, address 3, bit 0), every fault responds with rspErr high and a one-cycle faultEvt and never stalls. The same status bits as without the override are still recorded.
- R11: After reset all four registers read 0, and irq, stall, walkReq, rspValid and faultEvt are low while lkpReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkpValid | input | 1 | Lookup result present |
| lkpReady | output | 1 | Block can take a lookup |
| lkpHit | input | 1 | Lookup hit the buffer |
| lkpDebug | input | 1 | Lookup belongs to a debug access |
| lkpVaddr | input | VA_W | Virtual page of the lookup |
| lkpPaddr | input | PA_W | Physical page on a hit |
| rspValid | output | 1 | Access completion strobe |
| rspErr | output | 1 | Completion is an in-band bus error |
| rspPaddr | output | PA_W | Translated page of the completion |
| stall | output | 1 | Requester frozen pending host clear |
| walkReq | output | 1 | Table walk request |
| walkVaddr | output | VA_W | Page to walk |
| walkDone | input | 1 | Walker finished |
| walkOk | input | 1 | Walk found a translation |
| walkPaddr | input | PA_W | Page found by the walker |
| refillEn | output | 1 | Write a translation into the buffer |
| refillVaddr | output | VA_W | Virtual page to refill |
| refillPaddr | output | PA_W | Physical page to refill |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data (combinational) |
| irq | output | 1 | Fault interrupt |
| faultEvt | output | 1 | One-cycle pulse on an overridden fault |

## Verification
A controller stuck in the wrong state shows up at the ports within one cycle of the next lookup. It appears as a missing or extra response, a walkReq where a stall was due, or lkpReady staying high during a stall. A corrupted status or enable bit shows on irq in the same cycle and on a register read. A wrong refill decision shows as refillEn in the completion cycle of the walk. A stall that fails to release is caught one cycle after the clearing write, because the bench checks stall exactly there.

// File: rtl/mmu_disp_pkg.sv
package mmu_disp_pkg;
  localparam int STS_MISS  = 0;
  localparam int STS_FAULT = 1;
  localparam int STS_DBG   = 2;
  localparam int STS_W     = 3;

  localparam logic [1:0] ADDR_STS = 2'd0;
  localparam logic [1:0] ADDR_EN  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_GP  = 2'd3;

  localparam int CTL_WALK   = 1;
  localparam int CTL_DBGUPD = 3;
  localparam int GP_OVR     = 0;

  typedef struct packed {
    logic             capture;
    logic             rspLkp;
    logic             rspWalk;
    logic             rspErr;
    logic             refill;
    logic [STS_W-1:0] setSts;
    logic             evt;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_STALL} dispState_t;
endpackage

// File: rtl/mmu_disp_ctl.sv
module mmu_disp_ctl
  import mmu_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkpValid,
  input  logic       lkpHit,
  input  logic       lkpDebug,
  input  logic       walkDone,
  input  logic       walkOk,
  input  logic       reqDbg,
  input  logic       cfgWalkEn,
  input  logic       cfgDbgUpd,
  input  logic       cfgOvr,
  input  logic       stsAny,
  output ctlStrobe_t strb,
  output logic       lkpReady,
  output logic       stall,
  output logic       walkReq
);
  dispState_t stQ, stNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNxt;
  end

  always_comb begin
    strb  = '0;
    stNxt = stQ;
    case (stQ)
      ST_IDLE: begin
        if (lkpValid) begin
          strb.capture = 1'b1;
          if (lkpHit) begin
            strb.rspLkp = 1'b1;
          end else if (cfgWalkEn) begin
            stNxt = ST_WALK;
          end else begin
            strb.setSts[STS_DBG]  = lkpDebug;
            strb.setSts[STS_MISS] = !lkpDebug;
            if (cfgOvr) begin
              strb.rspErr = 1'b1;
              strb.evt    = 1'b1;
            end else begin
              stNxt = ST_STALL;
            end
          end
        end
      end
      ST_WALK: begin
        if (walkDone) begin
          stNxt = ST_IDLE;
          if (walkOk) begin
            strb.rspWalk = 1'b1;
            strb.refill  = !reqDbg || cfgDbgUpd;
          end else if (reqDbg) begin
            strb.rspErr = 1'b1;
            strb.evt    = cfgOvr;
          end else begin
            strb.setSts[STS_FAULT] = 1'b1;
            if (cfgOvr) begin
              strb.rspErr = 1'b1;
              strb.evt    = 1'b1;
            end else begin
              stNxt = ST_STALL;
            end
          end
        end
      end
      ST_STALL: begin
        if (!stsAny) stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  assign lkpReady = (stQ == ST_IDLE);
  assign stall    = (stQ == ST_STALL);
  assign walkReq  = (stQ == ST_WALK);
endmodule

// File: rtl/mmu_disp_dp.sv
module mmu_disp_dp
  import mmu_disp_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int PA_W  = 20,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic             lkpDebug,
  input  logic [VA_W-1:0]  lkpVaddr,
  input  logic [PA_W-1:0]  lkpPaddr,
  input  logic [PA_W-1:0]  walkPaddr,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic             reqDbg,
  output logic [VA_W-1:0]  walkVaddr,
  output logic             rspValid,
  output logic             rspErr,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             refillEn,
  output logic [VA_W-1:0]  refillVaddr,
  output logic [PA_W-1:0]  refillPaddr,
  output logic [REG_W-1:0] regRdData,
  output logic             irq,
  output logic             faultEvt,
  output logic             cfgWalkEn,
  output logic             cfgDbgUpd,
  output logic             cfgOvr,
  output logic             stsAny
);
  localparam int PAD_W = REG_W - STS_W;

  logic [VA_W-1:0]  vaQ;
  logic             dbgQ;
  logic [STS_W-1:0] stsQ, enQ, stsClr;
  logic [REG_W-1:0] ctlQ, gpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ  <= '0;
      dbgQ <= 1'b0;
    end else if (strb.capture) begin
      vaQ  <= lkpVaddr;
      dbgQ <= lkpDebug;
    end
  end

  assign stsClr = (regWrEn && regAddr == ADDR_STS) ? regWrData[STS_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ <= '0;
      enQ  <= '0;
      ctlQ <= '0;
      gpQ  <= '0;
    end else begin
      stsQ <= (stsQ & ~stsClr) | strb.setSts;
      if (regWrEn) begin
        case (regAddr)
          ADDR_EN:  enQ  <= regWrData[STS_W-1:0];
          ADDR_CTL: ctlQ <= regWrData;
          ADDR_GP:  gpQ  <= regWrData;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STS: regRdData = {{PAD_W{1'b0}}, stsQ};
      ADDR_EN:  regRdData = {{PAD_W{1'b0}}, enQ};
      ADDR_CTL: regRdData = ctlQ;
      default:  regRdData = gpQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      rspPaddr    <= '0;
      refillEn    <= 1'b0;
      refillVaddr <= '0;
      refillPaddr <= '0;
      faultEvt    <= 1'b0;
    end else begin
      rspValid <= strb.rspLkp | strb.rspWalk | strb.rspErr;
      rspErr   <= strb.rspErr;
      rspPaddr <= strb.rspLkp ? lkpPaddr : (strb.rspWalk ? walkPaddr : '0);
      refillEn <= strb.refill;
      faultEvt <= strb.evt;
      if (strb.refill) begin
        refillVaddr <= vaQ;
        refillPaddr <= walkPaddr;
      end
    end
  end

  assign reqDbg    = dbgQ;
  assign walkVaddr = vaQ;
  assign irq       = |(stsQ & enQ);
  assign stsAny    = |stsQ;
  assign cfgWalkEn = ctlQ[CTL_WALK];
  assign cfgDbgUpd = ctlQ[CTL_DBGUPD];
  assign cfgOvr    = gpQ[GP_OVR];
endmodule

// File: rtl/mmu_miss_dispatch.sv
module mmu_miss_dispatch
  import mmu_disp_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int PA_W  = 20,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkpValid,
  output logic             lkpReady,
  input  logic             lkpHit,
  input  logic             lkpDebug,
  input  logic [VA_W-1:0]  lkpVaddr,
  input  logic [PA_W-1:0]  lkpPaddr,
  output logic             rspValid,
  output logic             rspErr,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             stall,
  output logic             walkReq,
  output logic [VA_W-1:0]  walkVaddr,
  input  logic             walkDone,
  input  logic             walkOk,
  input  logic [PA_W-1:0]  walkPaddr,
  output logic             refillEn,
  output logic [VA_W-1:0]  refillVaddr,
  output logic [PA_W-1:0]  refillPaddr,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irq,
  output logic             faultEvt
);
  ctlStrobe_t strb;
  logic reqDbg, cfgWalkEn, cfgDbgUpd, cfgOvr, stsAny;

  mmu_disp_ctl i_ctl (
    .clk(clk), .rstN(rstN), .lkpValid(lkpValid), .lkpHit(lkpHit),
    .lkpDebug(lkpDebug), .walkDone(walkDone), .walkOk(walkOk),
    .reqDbg(reqDbg), .cfgWalkEn(cfgWalkEn), .cfgDbgUpd(cfgDbgUpd),
    .cfgOvr(cfgOvr), .stsAny(stsAny), .strb(strb), .lkpReady(lkpReady),
    .stall(stall), .walkReq(walkReq)
  );

  mmu_disp_dp #(.VA_W(VA_W), .PA_W(PA_W), .REG_W(REG_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lkpDebug(lkpDebug),
    .lkpVaddr(lkpVaddr), .lkpPaddr(lkpPaddr), .walkPaddr(walkPaddr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .reqDbg(reqDbg), .walkVaddr(walkVaddr), .rspValid(rspValid),
    .rspErr(rspErr), .rspPaddr(rspPaddr), .refillEn(refillEn),
    .refillVaddr(refillVaddr), .refillPaddr(refillPaddr),
    .regRdData(regRdData), .irq(irq), .faultEvt(faultEvt),
    .cfgWalkEn(cfgWalkEn), .cfgDbgUpd(cfgDbgUpd), .cfgOvr(cfgOvr),
    .stsAny(stsAny)
  );
endmodule

// File: rtl/mmu_disp_chk.sv
module mmu_disp_chk #(
  parameter int VA_W = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkpValid,
  input logic            lkpReady,
  input logic            lkpHit,
  input logic            rspValid,
  input logic            rspErr,
  input logic            stall,
  input logic            walkReq,
  input logic            walkDone,
  input logic [VA_W-1:0] walkVaddr,
  input logic            refillEn,
  input logic            faultEvt,
  input logic            regWrEn,
  input logic [1:0]      regAddr
);
  AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    lkpValid && lkpReady && lkpHit |=> rspValid && !rspErr); // R1
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !walkDone |=> walkReq && $stable(walkVaddr)); // R2
  AST_REFILL_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    refillEn |-> rspValid && !rspErr); // R2
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !rspValid && !walkReq && !lkpReady); // R4
  AST_RELEASE_BY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> $past(regWrEn && regAddr == 2'd0, 2)); // R9
  AST_EVT_IS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |-> rspValid && rspErr && !stall); // R10
endmodule

bind mmu_miss_dispatch mmu_disp_chk #(.VA_W(VA_W)) i_chk (
  .clk(clk), .rstN(rstN), .lkpValid(lkpValid), .lkpReady(lkpReady),
  .lkpHit(lkpHit), .rspValid(rspValid), .rspErr(rspErr), .stall(stall),
  .walkReq(walkReq), .walkDone(walkDone), .walkVaddr(walkVaddr),
  .refillEn(refillEn), .faultEvt(faultEvt), .regWrEn(regWrEn),
  .regAddr(regAddr)
);

// File: tb/test_mmu_miss_dispatch.sv
module test_mmu_miss_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 20;
  localparam int PA_W = 20;
  localparam int REG_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkpValid = 0, lkpHit = 0, lkpDebug = 0;
  logic [VA_W-1:0] lkpVaddr = '0;
  logic [PA_W-1:0] lkpPaddr = '0;
  logic walkDone = 0, walkOk = 0;
  logic [PA_W-1:0] walkPaddr = '0;
  logic regWrEn = 0;
  logic [1:0] regAddr = '0;
  logic [REG_W-1:0] regWrData = '0;
  logic lkpReady, rspValid, rspErr, stall, walkReq, refillEn, irq, faultEvt;
  logic [PA_W-1:0] rspPaddr, refillPaddr;
  logic [VA_W-1:0] walkVaddr, refillVaddr;
  logic [REG_W-1:0] regRdData;

  int nChk = 0, nBad = 0;
  logic [PA_W:0] expQ[$];
  string tagQ[$];

  mmu_miss_dispatch #(.VA_W(VA_W), .PA_W(PA_W), .REG_W(REG_W)) i_mmu_miss_dispatch (
    .clk(clk), .rstN(rstN), .lkpValid(lkpValid), .lkpReady(lkpReady),
    .lkpHit(lkpHit), .lkpDebug(lkpDebug), .lkpVaddr(lkpVaddr),
    .lkpPaddr(lkpPaddr), .rspValid(rspValid), .rspErr(rspErr),
    .rspPaddr(rspPaddr), .stall(stall), .walkReq(walkReq),
    .walkVaddr(walkVaddr), .walkDone(walkDone), .walkOk(walkOk),
    .walkPaddr(walkPaddr), .refillEn(refillEn), .refillVaddr(refillVaddr),
    .refillPaddr(refillPaddr), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .faultEvt(faultEvt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expectRsp(string tag, logic err, logic [PA_W-1:0] pa);
    expQ.push_back({err, pa});
    tagQ.push_back(tag);
  endtask

  // monitor: pops one expected item per completion
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        chk("R1 unexpected response", {11'd0, rspErr, rspPaddr}, 32'hFFFF_FFFF);
      end else begin
        logic [PA_W:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {11'd0, rspErr, rspPaddr}, {11'd0, e});
      end
    end
  end

  task automatic lookup(string tag, logic dbg, logic hit,
                        logic [VA_W-1:0] va, logic [PA_W-1:0] pa);
    @(negedge clk);
    chk({tag, " ready"}, lkpReady, 1);
    lkpValid = 1; lkpDebug = dbg; lkpHit = hit; lkpVaddr = va; lkpPaddr = pa;
    @(negedge clk);
    lkpValid = 0; lkpHit = 0; lkpDebug = 0;
  endtask

  task automatic walkResp(string tag, logic [VA_W-1:0] va, logic ok,
                          logic [PA_W-1:0] pa, logic expRefill);
    chk({tag, " walkReq"}, walkReq, 1);
    chk({tag, " walkVaddr"}, walkVaddr, va);
    walkDone = 1; walkOk = ok; walkPaddr = pa;
    @(negedge clk);
    walkDone = 0; walkOk = 0;
    chk({tag, " refillEn"}, refillEn, expRefill);
    if (expRefill) begin
      chk({tag, " refillVaddr"}, refillVaddr, va);
      chk({tag, " refillPaddr"}, refillPaddr, pa);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [REG_W-1:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(string tag, logic [1:0] a, logic [REG_W-1:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 4; a++) rdReg("R11 reg reset", a[1:0], 0);
    chk("R11 irq", irq, 0); chk("R11 stall", stall, 0);
    chk("R11 ready", lkpReady, 1); chk("R11 walkReq", walkReq, 0);
    chk("R11 rspValid", rspValid, 0); chk("R11 faultEvt", faultEvt, 0);
    rstN = 1;

    // R1 hits
    expectRsp("R1 hit a", 0, 20'h12345);
    lookup("R1", 0, 1, 20'h00AAA, 20'h12345);
    expectRsp("R1 hit b debug", 0, 20'hFEDCB);
    lookup("R1", 1, 1, 20'h00BBB, 20'hFEDCB);

    // R2 application walk success
    wrReg(2'd2, 8'h02);
    lookup("R2", 0, 0, 20'h0C0DE, 20'h0);
    expectRsp("R2 walk ok", 0, 20'h55AA5);
    walkResp("R2", 20'h0C0DE, 1, 20'h55AA5, 1);
    rdReg("R2 no status", 2'd0, 0);
    chk("R2 irq", irq, 0);

    // R5 debug walk success, refill gated
    lookup("R5", 1, 0, 20'h0D001, 20'h0);
    expectRsp("R5 dbg ok gated", 0, 20'h11111);
    walkResp("R5 no refill", 20'h0D001, 1, 20'h11111, 0);
    wrReg(2'd2, 8'h0A);
    lookup("R5", 1, 0, 20'h0D002, 20'h0);
    expectRsp("R5 dbg ok refill", 0, 20'h22222);
    walkResp("R5 refill", 20'h0D002, 1, 20'h22222, 1);

    // R6 debug walk failure
    lookup("R6", 1, 0, 20'h0D003, 20'h0);
    expectRsp("R6 dbg fail err", 1, 20'h0);
    walkResp("R6", 20'h0D003, 0, 20'h0, 0);
    chk("R6 stall", stall, 0);
    chk("R6 faultEvt", faultEvt, 0);
    rdReg("R6 no status", 2'd0, 0);

    // R3 application walk failure, R8 irq, R9 release
    wrReg(2'd1, 8'h07);
    lookup("R3", 0, 0, 20'h0E001, 20'h0);
    walkResp("R3", 20'h0E001, 0, 20'h0, 0);
    chk("R3 stall", stall, 1);
    chk("R3 ready low", lkpReady, 0);
    rdReg("R3 status", 2'd0, 8'h02);
    chk("R8 irq on", irq, 1);
    wrReg(2'd1, 8'h05);
    chk("R8 irq masked", irq, 0);
    wrReg(2'd1, 8'h07);
    chk("R8 irq back", irq, 1);
    wrReg(2'd0, 8'h02);
    chk("R9 stall one more cycle", stall, 1);
    @(negedge clk);
    chk("R9 stall released", stall, 0);
    chk("R9 ready back", lkpReady, 1);
    chk("R8 irq clear", irq, 0);

    // R4 application miss, walking off; R9 write-0 ignored
    wrReg(2'd2, 8'h00);
    lookup("R4", 0, 0, 20'h0F001, 20'h0);
    chk("R4 stall", stall, 1);
    chk("R4 irq", irq, 1);
    rdReg("R4 status", 2'd0, 8'h01);
    wrReg(2'd0, 8'h06);
    rdReg("R9 zero bits kept", 2'd0, 8'h01);
    chk("R9 still stalled", stall, 1);
    wrReg(2'd0, 8'h01);
    @(negedge clk);
    chk("R9 released", stall, 0);

    // R7 debug miss, walking off
    lookup("R7", 1, 0, 20'h0F002, 20'h0);
    chk("R7 stall", stall, 1);
    rdReg("R7 status", 2'd0, 8'h04);
    chk("R7 irq", irq, 1);
    wrReg(2'd0, 8'h04);
    @(negedge clk);
    chk("R7 released", stall, 0);

    // R10 override
    wrReg(2'd3, 8'h01);
    expectRsp("R10 miss err", 1, 20'h0);
    lookup("R10", 0, 0, 20'h0A001, 20'h0);
    chk("R10 evt miss", faultEvt, 1);
    chk("R10 no stall", stall, 0);
    @(negedge clk);
    chk("R10 evt one cycle", faultEvt, 0);
    rdReg("R10 miss status", 2'd0, 8'h01);
    wrReg(2'd0, 8'h07);
    wrReg(2'd2, 8'h02);
    lookup("R10", 0, 0, 20'h0A002, 20'h0);
    expectRsp("R10 walk fail err", 1, 20'h0);
    walkResp("R10", 20'h0A002, 0, 20'h0, 0);
    chk("R10 evt fault", faultEvt, 1);
    chk("R10 no stall fault", stall, 0);
    rdReg("R10 fault status", 2'd0, 8'h02);
    wrReg(2'd0, 8'h07);
    lookup("R10", 1, 0, 20'h0A003, 20'h0);
    expectRsp("R10 dbg fail err", 1, 20'h0);
    walkResp("R10", 20'h0A003, 0, 20'h0, 0);
    chk("R10 evt dbg", faultEvt, 1);

    repeat (3) @(negedge clk);
    chk("R1 all responses seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule